// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block sits behind a bank of threshold detectors of a parallel converter. It takes the 2^N − 1 already-digital level bits, lowest threshold at bit 0, and turns them into an N-bit binary code. A single extra detector bit marks input above full scale. That bit travels beside the code as a flag and never enters the encoding logic. Each code step stands for one equal slice of the input range, the full range divided by 2^N.

A healthy detector bank only produces monotone patterns: a set bit implies that every lower bit is also set. For those patterns the code is the number of set bits. Any other pattern gets a fixed policy: the code is the 1-based position of the highest set bit, and a bad-pattern flag is raised. This keeps the result deterministic when a bubble appears.

Samples enter and leave on valid/ready streams. With the parameter `REG_OUT` = 1, a one-entry output register separates the two sides. It accepts a new sample whenever it is empty or being drained in the same cycle, and it holds its contents steady while the consumer stalls. With `REG_OUT` = 0 the block is pure logic: valid and ready pass straight through.

Top module: `thermo_flash_encoder`

## Requirements
- R1: For width N, the block takes 2^N − 1 level bits (bit 0 = lowest threshold) plus one separate overflow bit, 2^N detector bits in all, and drives an N-bit code; N = 2, 3 and 4 are supported.
- R2: For a monotone level pattern, the code equals the number of set level bits: all clear gives 0 and all set gives 2^N − 1.
- R3: For a non-monotone level pattern (some bit set above a clear bit), the code equals the index plus one of the highest set level bit and bad_out is 1; for monotone patterns bad_out is 0.
- R4: ovf_out equals the overflow input of the same sample, and the overflow input changes neither the code nor bad_out.
- R5: With REG_OUT = 1, a sample accepted at a clock edge (in_valid and in_ready both high) is presented with out_valid high right after that edge; in_ready is high exactly when the register is empty or out_ready is high; while out_valid is high and out_ready is low, out_valid, code_out, ovf_out and bad_out hold their values.
- R6: With REG_OUT = 0, the results follow the inputs combinationally, with out_valid = in_valid and in_ready = out_ready.
- R7: With REG_OUT = 1, a synchronous active-high reset clears out_valid, code_out, ovf_out and bad_out to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block can take the sample |
| lvl_in | input | 2^N−1 | Thermometer level bits, bit 0 = lowest threshold |
| ovf_in | input | 1 | Above-full-scale detector bit |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| code_out | output | N | Binary code |
| ovf_out | output | 1 | Overflow flag of the sample |
| bad_out | output | 1 | Level pattern was not monotone |

## Verification
Two events can fall in the same cycle. First, the overflow flag and the bad-pattern flag can both be raised for one sample. The bench provokes this with random non-monotone patterns that carry the overflow bit. It then checks that the code still follows the highest set bit, with both flags present. Second, in the registered variant, a new sample can be accepted in the same cycle that the held result is drained. Also, a result must stay frozen while the consumer stalls. The bench drives out_ready in a stall pattern under back-to-back traffic, and its scoreboard checks the order and values of the results and their stability while stalled.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;
  // number of level inputs for an n-bit code
  function automatic int unsigned lvl_count(input int unsigned n);
    return (1 << n) - 1;
  endfunction
endpackage

// File: rtl/thermo_hsb_encoder.sv
module thermo_hsb_encoder #(
  parameter int unsigned N = 3,
  localparam int unsigned L = thermo_enc_pkg::lvl_count(N)
) (
  input  logic [L-1:0] lvl,
  output logic [N-1:0] code
);
  logic [L-1:0] clr_above;
  logic [L-1:0] hit;

  assign clr_above[L-1] = 1'b1;
  genvar gi;
  generate
    for (gi = 0; gi < L - 1; gi++) begin : g_chain
      assign clr_above[gi] = clr_above[gi+1] & ~lvl[gi+1];
    end
    for (gi = 0; gi < L; gi++) begin : g_hit
      assign hit[gi] = lvl[gi] & clr_above[gi];
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < L; i++) begin
      if (hit[i]) code = code | N'(i + 1);
    end
  end
endmodule

// File: rtl/thermo_monotone_check.sv
module thermo_monotone_check #(
  parameter int unsigned N = 3,
  localparam int unsigned L = thermo_enc_pkg::lvl_count(N)
) (
  input  logic [L-1:0] lvl,
  output logic         bad
);
  logic [L-2:0] gap;
  genvar gi;
  generate
    for (gi = 1; gi < L; gi++) begin : g_gap
      assign gap[gi-1] = lvl[gi] & ~lvl[gi-1];
    end
  endgenerate
  assign bad = |gap;
endmodule

// File: rtl/thermo_out_stage.sv
module thermo_out_stage #(
  parameter int unsigned W   = 5,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      assign in_ready  = ~vld_q | out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end

      p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      p_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
      p_reset_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/thermo_flash_encoder.sv
module thermo_flash_encoder #(
  parameter int unsigned N       = 3,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned L = thermo_enc_pkg::lvl_count(N),
  localparam int unsigned W = N + 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [L-1:0] lvl_in,
  input  logic         ovf_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] code_out,
  output logic         ovf_out,
  output logic         bad_out
);
  logic [N-1:0] enc_code;
  logic         chk_bad;
  logic [W-1:0] res_d;
  logic [W-1:0] res_q;

  thermo_hsb_encoder #(.N(N)) u_enc (
    .lvl  (lvl_in),
    .code (enc_code)
  );

  thermo_monotone_check #(.N(N)) u_chk (
    .lvl (lvl_in),
    .bad (chk_bad)
  );

  // overflow rides alongside, never into the encoder
  assign res_d = {enc_code, ovf_in, chk_bad};

  thermo_out_stage #(.W(W), .REG(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign code_out = res_q[W-1:2];
  assign ovf_out  = res_q[1];
  assign bad_out  = res_q[0];

  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    !chk_bad |-> (int'(enc_code) == $countones(lvl_in)));
  p_full_r2: assert property (@(posedge clk) disable iff (rst)
    (&lvl_in) |-> (&enc_code && !chk_bad));
  p_invalid_r3: assert property (@(posedge clk) disable iff (rst)
    chk_bad |-> (int'(enc_code) > $countones(lvl_in)));
endmodule

// File: tb/sim_thermo_flash_encoder.sv
module sim_thermo_flash_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // u0: N=4, registered
  logic        a_iv = 1'b0, a_ir, a_ov, a_or = 1'b1, a_ovfi = 1'b0, a_ovfo, a_bad;
  logic [14:0] a_lvl = '0;
  logic [3:0]  a_code;
  thermo_flash_encoder #(.N(4), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .lvl_in(a_lvl),
    .ovf_in(a_ovfi), .out_valid(a_ov), .out_ready(a_or), .code_out(a_code),
    .ovf_out(a_ovfo), .bad_out(a_bad));

  // u1: N=2, combinational
  logic       b_iv = 1'b0, b_ir, b_ov, b_or = 1'b0, b_ovfi = 1'b0, b_ovfo, b_bad;
  logic [2:0] b_lvl = '0;
  logic [1:0] b_code;
  thermo_flash_encoder #(.N(2), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .lvl_in(b_lvl),
    .ovf_in(b_ovfi), .out_valid(b_ov), .out_ready(b_or), .code_out(b_code),
    .ovf_out(b_ovfo), .bad_out(b_bad));

  // u2: N=3, combinational
  logic       c_iv = 1'b1, c_ir, c_ov, c_or = 1'b1, c_ovfi = 1'b0, c_ovfo, c_bad;
  logic [6:0] c_lvl = '0;
  logic [2:0] c_code;
  thermo_flash_encoder #(.N(3), .REG_OUT(1'b0)) u2 (
    .clk(clk), .rst(rst), .in_valid(c_iv), .in_ready(c_ir), .lvl_in(c_lvl),
    .ovf_in(c_ovfi), .out_valid(c_ov), .out_ready(c_or), .code_out(c_code),
    .ovf_out(c_ovfo), .bad_out(c_bad));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic bit ref_bad(input logic [14:0] v, input int nl);
    for (int i = 1; i < nl; i++) if (v[i] && !v[i-1]) return 1'b1;
    return 1'b0;
  endfunction
  function automatic int ref_code(input logic [14:0] v, input int nl);
    int pc = 0;
    int hi = 0;
    for (int i = 0; i < nl; i++) begin
      if (v[i]) begin
        pc++;
        hi = i + 1;
      end
    end
    return ref_bad(v, nl) ? hi : pc;
  endfunction

  // scoreboard for u0: {code, ovf, bad}
  logic [5:0] sb_q[$];
  bit stall_mode = 1'b0;
  int cyc = 0;

  task automatic send(input logic [14:0] v, input logic ovf);
    a_lvl = v;
    a_ovfi = ovf;
    a_iv = 1'b1;
    @(negedge clk);
    while (!a_ir) @(negedge clk);
    sb_q.push_back({4'(ref_code(v, 15)), ovf, ref_bad(v, 15)});
    @(posedge clk);
    #1 a_iv = 1'b0;
  endtask

  // out_ready driver
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 a_or <= stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor
  logic       held_v = 1'b0;
  logic [5:0] held_d = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (held_v) begin
        chk(a_ov && {a_code, a_ovfo, a_bad} == held_d, "R5 hold under stall",
            int'({a_code, a_ovfo, a_bad}), int'(held_d));
      end
      if (a_ov && !a_or)
        chk(!a_ir, "R5 in_ready low when full and stalled", int'(a_ir), 0);
      held_v = a_ov && !a_or;
      held_d = {a_code, a_ovfo, a_bad};
      if (a_ov && a_or) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5 unexpected result", int'(a_code), -1);
        end else begin
          logic [5:0] e;
          e = sb_q.pop_front();
          chk({a_code, a_ovfo, a_bad} == e, "R2 R3 R4 scoreboard result",
              int'({a_code, a_ovfo, a_bad}), int'(e));
        end
      end
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state, R7
    repeat (3) @(posedge clk);
    #1;
    chk(!a_ov && a_code == 0 && !a_ovfo && !a_bad, "R7 reset clears outputs",
        int'({a_ov, a_code, a_ovfo, a_bad}), 0);
    rst = 1'b0;
    @(posedge clk);
    #1;

    // R5 latency: one sample into an empty register
    send(15'h0007, 1'b0);
    chk(a_ov && a_code == 4'd3, "R5 valid right after accept", int'(a_code), 3);

    // R1 R2: all legal patterns for N=4, with R4 overflow on the top one
    for (int k = 0; k <= 15; k++) send(15'((1 << k) - 1), 1'b0);
    send(15'h7fff, 1'b1);
    send(15'h0000, 1'b1);

    // R3 R4 under back-pressure, random patterns
    stall_mode = 1'b1;
    for (int k = 0; k < 200; k++) send(15'($urandom), 1'($urandom));
    stall_mode = 1'b0;

    // R6 R1 R2 R3 R4: exhaustive on the combinational widths
    for (int v = 0; v < 8; v++) begin
      for (int o = 0; o < 2; o++) begin
        b_lvl = 3'(v);
        b_ovfi = 1'(o);
        #1;
        chk(b_code == 2'(ref_code(15'(v), 3)), "R2 R3 code N=2",
            int'(b_code), ref_code(15'(v), 3));
        chk(b_bad == ref_bad(15'(v), 3), "R3 flag N=2", int'(b_bad), int'(ref_bad(15'(v), 3)));
        chk(b_ovfo == 1'(o), "R4 overflow N=2", int'(b_ovfo), o);
      end
    end
    b_iv = 1'b1; b_or = 1'b0; #1;
    chk(b_ov && !b_ir, "R6 passthrough valid/ready", int'({b_ov, b_ir}), 2);
    b_iv = 1'b0; b_or = 1'b1; #1;
    chk(!b_ov && b_ir, "R6 passthrough valid/ready", int'({b_ov, b_ir}), 1);
    for (int v = 0; v < 128; v++) begin
      c_lvl = 7'(v);
      c_ovfi = 1'(v % 3 == 0);
      #1;
      chk(c_code == 3'(ref_code(15'(v), 7)), "R2 R3 code N=3",
          int'(c_code), ref_code(15'(v), 7));
      chk(c_bad == ref_bad(15'(v), 7), "R3 flag N=3", int'(c_bad), int'(ref_bad(15'(v), 7)));
      chk(c_ovfo == 1'(v % 3 == 0) && c_ov, "R4 overflow N=3", int'(c_ovfo), int'(v % 3 == 0));
    end

    // drain and finish
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(sb_q.size() == 0, "R5 all results delivered", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule